// File: doc/BRIEF.md
# Rotating-Priority Interrupt Request Resolver

This block is the request stage and priority resolver of an eight-line interrupt controller. Each request line is captured into a request register. A per-line trigger-mode bit makes the line either level-sensitive or edge-sensitive. An edge-sensitive line keeps a stored copy of the previous input level, so that only a low-to-high change sets its request bit.

The resolver removes masked requests and finds the best pending request. It also finds the best level currently in service, which comes from an in-service vector supplied by the surrounding command logic. Both searches use a rotating priority order. Priority index 0 is the highest, and index k belongs to line (k + base) mod 8, where base is a registered rotation base loaded from an input. The interrupt output is raised only when the pending request strictly outranks everything in service. When special nesting is selected, the cascade line's in-service bit is left out of that comparison.

The interrupt output and the winning line number are registered. Command decoding and vector generation belong to the neighbouring logic, which also clears acknowledged edge requests through a clear vector.

Top module: `irq_resolver`

## Requirements
- R1: While `rst_n` is low, the request register, the stored previous levels, the rotation base, `irq_out` and `irq_line` are all zero.
- R2: A line whose `trig_level` bit is 1 (level-sensitive) has its `req_pending` bit equal to its `req_in` level at the previous clock edge, and `ack_clear` has no effect on it.
- R3: A line whose `trig_level` bit is 0 (edge-sensitive) sets its `req_pending` bit one cycle after `req_in` changes from low to high. A low or a steady-high input leaves the bit unchanged.
- R4: An `ack_clear` bit of 1 clears an edge-sensitive request bit on the next edge, unless a new rising edge on that line arrives in the same cycle, in which case the bit is set.
- R5: A request whose `irq_mask` bit is 1 takes no part in arbitration.
- R6: The order of priority is rotated. Index k (0 is the highest) maps to line (k + base) mod 8. The base is loaded from `rot_base_in` when `rot_load` is 1 and takes effect from the following cycle.
- R7: `irq_out` is 1 only when the best unmasked pending index is strictly smaller than the best index set in `in_service`. An empty vector counts as index 8 (none).
- R8: When `nest_special` is 1, bit 2 of `in_service` (the cascade line) is ignored in the in-service comparison.
- R9: `irq_out` and `irq_line` are registered one cycle after the request state, mask, in-service and base they are computed from. `irq_line` equals (winning index + base) mod 8 when `irq_out` is 1, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| req_in | input | 8 | Raw interrupt request lines |
| trig_level | input | 8 | Per-line trigger mode: 1 = level, 0 = edge |
| ack_clear | input | 8 | Clears edge-sensitive request bits |
| irq_mask | input | 8 | Per-line mask: 1 = blocked |
| in_service | input | 8 | Lines currently in service |
| rot_base_in | input | 3 | New rotation base |
| rot_load | input | 1 | Load `rot_base_in` into the rotation base |
| nest_special | input | 1 | Ignore the cascade line's in-service bit |
| req_pending | output | 8 | Request register |
| irq_out | output | 1 | Registered interrupt request |
| irq_line | output | 3 | Registered winning line number |

## Verification
The hardest situation to reach is a pending request that is strictly better than everything in service under a rotated base. The difficulty is that the rotation base is internal state and cannot be read back. The stimulus reaches it by loading a base, holding in-service vectors that straddle the wrap-around point of the rotated order, and then seeing which line wins. It also drives a same-cycle rising edge together with an acknowledge clear, and toggles special nesting while the cascade bit is the only one in service. A behavioural model of the rotated order is compared with the outputs on every cycle, including during random stretches.

// File: rtl/irq_res_pkg.sv
package irq_res_pkg;
  localparam int unsigned IRQ_LINES   = 8;
  localparam int unsigned IRQ_IDX_W   = $clog2(IRQ_LINES);
  localparam int unsigned IRQ_CASCADE = 2;
endpackage

// File: rtl/irq_capture.sv
module irq_capture #(
  parameter int unsigned N = irq_res_pkg::IRQ_LINES
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req_in,
  input  logic [N-1:0] trig_level,
  input  logic [N-1:0] ack_clear,
  output logic [N-1:0] req_q
);
  logic [N-1:0] prev_q;
  logic [N-1:0] req_d;
  logic [N-1:0] prev_d;
  logic         cap_en;

  assign cap_en = 1'b1;

  for (genvar i = 0; i < N; i++) begin : g_line
    always_comb begin
      prev_d[i] = req_in[i];
      if (trig_level[i]) begin
        req_d[i] = req_in[i];
      end else if (req_in[i] && !prev_q[i]) begin
        req_d[i] = 1'b1;
      end else if (ack_clear[i]) begin
        req_d[i] = 1'b0;
      end else begin
        req_d[i] = req_q[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= '0;
      prev_q <= '0;
    end else if (cap_en) begin
      req_q  <= req_d;
      prev_q <= prev_d;
    end
  end
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int unsigned N  = irq_res_pkg::IRQ_LINES,
  parameter int unsigned IW = irq_res_pkg::IRQ_IDX_W
) (
  input  logic [N-1:0]  vec,
  input  logic [IW-1:0] base,
  output logic [IW:0]   rank
);
  always_comb begin
    rank = IW'(0) + (IW+1)'(N);
    for (int k = N - 1; k >= 0; k--) begin
      if (vec[(k + int'(base)) % N]) rank = (IW+1)'(k);
    end
  end
endmodule

// File: rtl/irq_resolver.sv
module irq_resolver #(
  parameter int unsigned N       = irq_res_pkg::IRQ_LINES,
  parameter int unsigned CASCADE = irq_res_pkg::IRQ_CASCADE,
  localparam int unsigned IW     = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req_in,
  input  logic [N-1:0]  trig_level,
  input  logic [N-1:0]  ack_clear,
  input  logic [N-1:0]  irq_mask,
  input  logic [N-1:0]  in_service,
  input  logic [IW-1:0] rot_base_in,
  input  logic          rot_load,
  input  logic          nest_special,
  output logic [N-1:0]  req_pending,
  output logic          irq_out,
  output logic [IW-1:0] irq_line
);
  logic [IW-1:0] base_q;
  logic [N-1:0]  pend_vec;
  logic [N-1:0]  isr_vec;
  logic [IW:0]   pend_rank;
  logic [IW:0]   isr_rank;
  logic          win_d;
  logic [IW-1:0] line_d;
  logic          out_en;

  irq_capture #(.N(N)) u_cap (
    .clk(clk), .rst_n(rst_n), .req_in(req_in), .trig_level(trig_level),
    .ack_clear(ack_clear), .req_q(req_pending)
  );

  always_comb begin
    pend_vec = req_pending & ~irq_mask;
    isr_vec  = in_service;
    if (nest_special) isr_vec[CASCADE] = 1'b0;
  end

  irq_prio_pick #(.N(N), .IW(IW)) u_pick_pend (
    .vec(pend_vec), .base(base_q), .rank(pend_rank)
  );
  irq_prio_pick #(.N(N), .IW(IW)) u_pick_isr (
    .vec(isr_vec), .base(base_q), .rank(isr_rank)
  );

  always_comb begin
    win_d  = pend_rank < isr_rank;
    line_d = '0;
    if (win_d) line_d = IW'((int'(pend_rank) + int'(base_q)) % N);
  end

  assign out_en = 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q   <= '0;
    end else if (rot_load) begin
      base_q   <= rot_base_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_out  <= 1'b0;
      irq_line <= '0;
    end else if (out_en) begin
      irq_out  <= win_d;
      irq_line <= line_d;
    end
  end
endmodule

// File: rtl/irq_resolver_chk.sv
module irq_resolver_chk #(
  parameter int unsigned N  = 8,
  parameter int unsigned IW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic [N-1:0]  req_in,
  input logic [N-1:0]  trig_level,
  input logic [N-1:0]  ack_clear,
  input logic [N-1:0]  irq_mask,
  input logic [N-1:0]  req_pending,
  input logic          irq_out,
  input logic [IW-1:0] irq_line
);
  logic armed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  AST_LEVEL_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> (((req_pending ^ $past(req_in)) & $past(trig_level)) == '0)); // R2

  AST_EDGE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> (($past(req_pending) & ~req_pending & ~$past(trig_level) & ~$past(ack_clear)) == '0)); // R3

  AST_MASKED_NEVER_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && irq_out) |-> ((($past(req_pending) & ~$past(irq_mask)) >> irq_line) & 1) == 1); // R5

  AST_IDLE_LINE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_out |-> (irq_line == '0)); // R9

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |-> (!irq_out && req_pending == '0)); // R1
endmodule

bind irq_resolver irq_resolver_chk #(.N(N), .IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_in(req_in), .trig_level(trig_level),
  .ack_clear(ack_clear), .irq_mask(irq_mask), .req_pending(req_pending),
  .irq_out(irq_out), .irq_line(irq_line)
);

// File: tb/irq_resolver_test.sv
module irq_resolver_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] req_in = '0, trig_level = '0, ack_clear = '0, irq_mask = '0, in_service = '0;
  logic [2:0] rot_base_in = '0;
  logic       rot_load = 1'b0, nest_special = 1'b0;
  logic [7:0] req_pending;
  logic       irq_out;
  logic [2:0] irq_line;

  int tests = 0, fails = 0;
  int m_req[8], m_prev[8];
  int m_base = 0, m_out = 0, m_line = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  irq_resolver uut (
    .clk(clk), .rst_n(rst_n), .req_in(req_in), .trig_level(trig_level),
    .ack_clear(ack_clear), .irq_mask(irq_mask), .in_service(in_service),
    .rot_base_in(rot_base_in), .rot_load(rot_load), .nest_special(nest_special),
    .req_pending(req_pending), .irq_out(irq_out), .irq_line(irq_line)
  );

  function automatic int best(int v[8], int b);
    for (int k = 0; k < 8; k++) if (v[(k + b) % 8] != 0) return k;
    return 8;
  endfunction

  // behavioural reference, advanced on every rising edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) begin m_req[i] = 0; m_prev[i] = 0; end
      m_base = 0; m_out = 0; m_line = 0;
    end else begin
      int pv[8], iv[8], pk, ck;
      for (int i = 0; i < 8; i++) begin
        pv[i] = (m_req[i] != 0 && !irq_mask[i]) ? 1 : 0;
        iv[i] = (in_service[i] && !(nest_special && i == 2)) ? 1 : 0;
      end
      pk = best(pv, m_base);
      ck = best(iv, m_base);
      m_out  = (pk < ck) ? 1 : 0;
      m_line = m_out ? (pk + m_base) % 8 : 0;
      for (int i = 0; i < 8; i++) begin
        if (trig_level[i]) m_req[i] = req_in[i];
        else if (req_in[i] && m_prev[i] == 0) m_req[i] = 1;
        else if (ack_clear[i]) m_req[i] = 0;
        m_prev[i] = req_in[i];
      end
      if (rot_load) m_base = rot_base_in;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int mreq_vec();
    int v = 0;
    for (int i = 0; i < 8; i++) if (m_req[i] != 0) v |= (1 << i);
    return v;
  endfunction

  // every-cycle comparison against the model (R9 timing, R6 order)
  always @(negedge clk) if (rst_n) begin
    cyc++;
    chk(req_pending == 8'(mreq_vec()), "R9 model req", int'(req_pending), mreq_vec());
    chk(irq_out == 1'(m_out), "R9 model irq", int'(irq_out), m_out);
    chk(irq_line == 3'(m_line), "R9 model line", int'(irq_line), m_line);
  end

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(req_pending == 0 && irq_out == 0 && irq_line == 0, "R1 reset", int'(req_pending), 0);
    rst_n = 1'b1;
    tick(1);
    // R2 level line follows input
    trig_level = 8'h01; req_in = 8'h01; ack_clear = 8'h01;
    tick(1);
    chk(req_pending == 8'h01, "R2 level high", int'(req_pending), 1);
    req_in = 8'h00; ack_clear = '0; tick(1);
    chk(req_pending == 8'h00, "R2 level low", int'(req_pending), 0);
    // R3 edge capture, steady/low do not clear
    trig_level = '0; req_in = 8'h08; tick(1);
    chk(req_pending == 8'h08, "R3 rise sets", int'(req_pending), 8);
    req_in = 8'h00; tick(2);
    chk(req_pending == 8'h08, "R3 low keeps", int'(req_pending), 8);
    chk(irq_out == 1 && irq_line == 3, "R7 lone request", int'(irq_line), 3);
    // R5 mask
    irq_mask = 8'h08; tick(1);
    chk(irq_out == 0, "R5 masked", int'(irq_out), 0);
    irq_mask = '0;
    // R4 ack clears, steady high stays clear
    req_in = 8'h08; ack_clear = 8'h08; tick(1);
    chk(req_pending == 8'h08, "R4 edge beats clear", int'(req_pending), 8);
    tick(1);
    chk(req_pending == 8'h00, "R4 clear", int'(req_pending), 0);
    ack_clear = '0; tick(1);
    chk(req_pending == 8'h00, "R3 steady high no set", int'(req_pending), 0);
    // R6 rotation: pending lines 0 and 5
    req_in = 8'h00; tick(1);
    req_in = 8'h21; tick(1);
    rot_base_in = 3'd5; rot_load = 1'b1; tick(1);
    rot_load = 1'b0; tick(1);
    chk(irq_out == 1 && irq_line == 5, "R6 base 5", int'(irq_line), 5);
    rot_base_in = 3'd0; rot_load = 1'b1; tick(1);
    rot_load = 1'b0; tick(1);
    chk(irq_out == 1 && irq_line == 0, "R6 base 0", int'(irq_line), 0);
    // R7 strict compare
    in_service = 8'h01; tick(1);
    chk(irq_out == 0, "R7 equal level", int'(irq_out), 0);
    irq_mask = 8'h01; in_service = 8'h10; tick(1);
    chk(irq_out == 0, "R7 lower than isr", int'(irq_out), 0);
    in_service = 8'h40; tick(1);
    chk(irq_out == 1 && irq_line == 5, "R7 better than isr", int'(irq_line), 5);
    // R8 special nesting ignores cascade bit
    irq_mask = 8'h01; in_service = 8'h04; tick(1);
    chk(irq_out == 0, "R8 cascade counted", int'(irq_out), 0);
    nest_special = 1'b1; tick(1);
    chk(irq_out == 1 && irq_line == 5, "R8 cascade ignored", int'(irq_line), 5);
    nest_special = 1'b0; irq_mask = '0; in_service = '0;
    // random stretch, compared by the model
    for (int n = 0; n < 400; n++) begin
      req_in = 8'($urandom); trig_level = 8'($urandom); ack_clear = 8'($urandom);
      irq_mask = 8'($urandom & $urandom); in_service = 8'($urandom & $urandom & $urandom);
      rot_base_in = 3'($urandom); rot_load = ($urandom % 5) == 0;
      nest_special = 1'($urandom);
      tick(1);
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule